// File: doc/BRIEF.md
# Management PHY Register Responder

This block stands in for a management interface and the PHY behind it. A host uses a small synchronous register port to set a management configuration word, load a write-data word and issue a command word. The command word names a PHY address, a register index and an operation. When the command's start flag is set and the operation is valid, the block performs one access to a built-in 32 x 16-bit PHY register set. A write stores data. A read copies the result into a read-data register that the host can fetch later.

The emulated PHY answers at one address, which is fixed by a parameter. Any other address behaves like an empty bus position. Several PHY registers are not stored; they are derived on every read from a link input and from the advertisement register. Each command finishes in the cycle after it is written, and a one-cycle done pulse marks that completion. There is no serial bus signalling and no clock division.

Top module: `mgmt_phy_responder`

## Requirements
- R1: A host write to command offset 1 with start (bit 11) set and operation bits 15:14 equal to 1 (write) or 2 (read) raises `cmdDone` for exactly the following cycle. Any other host write leaves `cmdDone` low.
- R2: A write command stores the low 16 bits of the write-data register (offset 2) into the PHY register selected by command bits 20:16. A later read command returns the stored value for every stored register. The write-data register reads back all 32 bits as written.
- R3: A read command whose PHY address (bits 28:24) differs from the `PHY_ADDR` parameter (default 7) returns 0xFFFF. A write command to such an address changes no PHY register.
- R4: Reading the command register (offset 1) returns the last word written with bit 7 forced to 1. After reset this is 0x00000080.
- R5: A write to the configuration register (offset 0) keeps only bits 6:0. Bit 6 is the enable and bits 5:0 are the divider. The upper bits always read as zero, and the register is 0 after reset.
- R6: After reset, PHY register 0 is 0x3100, register 2 is 0x0300, register 3 is 0xE400, register 4 is 0x01E1, and every other stored register is 0.
- R7: PHY register 1 reads 0x782E when `linkUp` is 1 (bits 14, 13, 12, 11, 5, 3, 2 and 1) and reads 0 when `linkUp` is 0.
- R8: PHY register 5 reads 0x4000, OR register 4 masked with 0x01E0, OR 0x0001.
- R9: PHY register 17 reads 0x8000. With `linkUp` = 1, register 18 has bit 10 set when register 4 has 0x0080 or 0x0100 set, and bit 11 set when register 4 has 0x0100 or 0x0040 set. All its other bits are 0. With `linkUp` = 0, register 18 reads 0.
- R10: After any PHY register write, bit 15 of PHY register 0 is clear. Writing 0xFFFF to register 0 reads back 0x7FFF.
- R11: A command word with start set but operation 0 or 3, or with start clear, changes neither the read-data register (offset 3) nor any PHY register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkUp | input | 1 | Link state seen by the emulated PHY |
| regWrEn | input | 1 | Host write strobe |
| regAddr | input | 2 | Host register offset (0 config, 1 command, 2 write data, 3 read data) |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Host read data for `regAddr`, combinational |
| cmdDone | output | 1 | One-cycle pulse when a PHY access completes |

## Verification
The bench reads all 32 PHY registers after reset and after a write of a distinct pattern to each one. This exposes any register that stores a value where it should derive one, or the reverse. It sweeps all sixteen advertisement combinations with the link up and down. A wrong mask or a swapped OR term in the diagnostic or partner registers would show up as a single mismatched bit. The bench probes every foreign PHY address. A responder that ignored the address field would return real data instead of 0xFFFF, or would let a foreign write corrupt its own registers. The bench issues invalid opcodes and commands with start clear. A decoder that treated these as reads would both pulse done and overwrite the read-data register.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;
  localparam int HOST_DW   = 32;
  localparam int HOST_AW   = 2;
  localparam int PHY_DW    = 16;
  localparam int PHY_RW    = 5;
  localparam int PHY_NREG  = 1 << PHY_RW;
  localparam int CFG_W     = 7;

  // host register offsets
  localparam logic [HOST_AW-1:0] OFS_CFG   = 2'd0;
  localparam logic [HOST_AW-1:0] OFS_CMD   = 2'd1;
  localparam logic [HOST_AW-1:0] OFS_WDATA = 2'd2;
  localparam logic [HOST_AW-1:0] OFS_RDATA = 2'd3;

  // command word fields
  localparam int CMD_PHY_LO   = 24;
  localparam int CMD_REG_LO   = 16;
  localparam int CMD_OP_LO    = 14;
  localparam int CMD_START    = 11;
  localparam int CMD_READY    = 7;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } phyOp_e;

  // strobes from control to the PHY datapath
  typedef struct packed {
    logic              phyWr;
    logic              phyRd;
    logic              hit;
    logic [PHY_RW-1:0] regIdx;
    logic [PHY_DW-1:0] wrData;
  } phyStrobe_t;
endpackage

// File: rtl/mgmt_host_ctrl.sv
module mgmt_host_ctrl
  import mgmt_phy_pkg::*;
#(
  parameter logic [PHY_RW-1:0] PHY_ADDR = 5'd7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [HOST_AW-1:0] regAddr,
  input  logic [HOST_DW-1:0] regWrData,
  output logic [HOST_DW-1:0] regRdData,
  input  logic [PHY_DW-1:0]  phyRdValue,
  output phyStrobe_t         strobe,
  output logic               cmdDone
);
  logic [CFG_W-1:0]   cfgReg;
  logic [HOST_DW-1:0] cmdReg;
  logic [HOST_DW-1:0] wdataReg;
  logic [PHY_DW-1:0]  rdataReg;

  logic   cmdSel;
  logic   startBit;
  phyOp_e opField;

  assign cmdSel   = regWrEn && (regAddr == OFS_CMD);
  assign startBit = regWrData[CMD_START];
  assign opField  = phyOp_e'(regWrData[CMD_OP_LO +: 2]);

  always_comb begin
    strobe.phyWr  = cmdSel && startBit && (opField == OP_WRITE);
    strobe.phyRd  = cmdSel && startBit && (opField == OP_READ);
    strobe.hit    = (regWrData[CMD_PHY_LO +: PHY_RW] == PHY_ADDR);
    strobe.regIdx = regWrData[CMD_REG_LO +: PHY_RW];
    strobe.wrData = wdataReg[PHY_DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg   <= '0;
      cmdReg   <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
      cmdDone  <= 1'b0;
    end else begin
      cmdDone <= strobe.phyWr || strobe.phyRd;
      if (strobe.phyRd) rdataReg <= phyRdValue;
      if (regWrEn) begin
        case (regAddr)
          OFS_CFG:   cfgReg   <= regWrData[CFG_W-1:0];
          OFS_CMD:   cmdReg   <= regWrData;
          OFS_WDATA: wdataReg <= regWrData;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      OFS_CFG:   regRdData = {{(HOST_DW-CFG_W){1'b0}}, cfgReg};
      OFS_CMD:   regRdData = cmdReg | (HOST_DW'(1) << CMD_READY);
      OFS_WDATA: regRdData = wdataReg;
      default:   regRdData = {{(HOST_DW-PHY_DW){1'b0}}, rdataReg};
    endcase
  end
endmodule

// File: rtl/mgmt_phy_regfile.sv
module mgmt_phy_regfile
  import mgmt_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  phyStrobe_t        strobe,
  output logic [PHY_DW-1:0] phyRdValue
);
  localparam logic [PHY_DW-1:0] ADV_10F   = 16'h0040;
  localparam logic [PHY_DW-1:0] ADV_100H  = 16'h0080;
  localparam logic [PHY_DW-1:0] ADV_100F  = 16'h0100;
  localparam logic [PHY_DW-1:0] ADV_MASK  = 16'h01E0;
  localparam logic [PHY_DW-1:0] STAT_LINK = 16'h782E;
  localparam logic [PHY_DW-1:0] RST_BIT   = 16'h8000;

  logic [PHY_DW-1:0] store [PHY_NREG];
  logic [PHY_DW-1:0] advReg;
  logic [PHY_DW-1:0] derived;
  logic              dup, fast;

  assign advReg = store[4];
  assign fast   = |(advReg & (ADV_100H | ADV_100F));
  assign dup    = |(advReg & (ADV_100F | ADV_10F));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHY_NREG; i++) store[i] <= '0;
      store[0] <= 16'h3100;
      store[2] <= 16'h0300;
      store[3] <= 16'hE400;
      store[4] <= 16'h01E1;
    end else if (strobe.phyWr && strobe.hit) begin
      if (strobe.regIdx == '0) begin
        store[0] <= strobe.wrData & ~RST_BIT;
      end else begin
        store[strobe.regIdx] <= strobe.wrData;
        store[0]             <= store[0] & ~RST_BIT;
      end
    end
  end

  always_comb begin
    case (strobe.regIdx)
      5'd1:    derived = linkUp ? STAT_LINK : '0;
      5'd5:    derived = 16'h4000 | (advReg & ADV_MASK) | 16'h0001;
      5'd17:   derived = 16'h8000;
      5'd18:   derived = linkUp ? {4'b0, dup, fast, 10'b0} : '0;
      default: derived = store[strobe.regIdx];
    endcase
    phyRdValue = strobe.hit ? derived : '1;
  end
endmodule

// File: rtl/mgmt_phy_responder.sv
module mgmt_phy_responder
  import mgmt_phy_pkg::*;
#(
  parameter logic [PHY_RW-1:0] PHY_ADDR = 5'd7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               linkUp,
  input  logic               regWrEn,
  input  logic [HOST_AW-1:0] regAddr,
  input  logic [HOST_DW-1:0] regWrData,
  output logic [HOST_DW-1:0] regRdData,
  output logic               cmdDone
);
  phyStrobe_t        strobe;
  logic [PHY_DW-1:0] phyRdValue;

  mgmt_host_ctrl #(.PHY_ADDR(PHY_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .phyRdValue(phyRdValue),
    .strobe(strobe), .cmdDone(cmdDone)
  );

  mgmt_phy_regfile phy_i (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .strobe(strobe),
    .phyRdValue(phyRdValue)
  );
endmodule

// File: rtl/mgmt_phy_checker.sv
module mgmt_phy_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic        cmdStart,
  input logic [1:0]  cmdOp,
  input logic [31:0] regRdData,
  input logic        cmdDone
);
  AST_READY_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd1) |-> regRdData[7]); // R4

  AST_CFG_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> (regRdData[31:7] == '0)); // R5

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> $past(regWrEn && regAddr == 2'd1 && cmdStart &&
                      (cmdOp == 2'd1 || cmdOp == 2'd2))); // R1

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3 && $past(regAddr == 2'd3) && !cmdDone) |-> $stable(regRdData)); // R11

  AST_RDATA_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> (regRdData[31:16] == '0)); // R3
endmodule

bind mgmt_phy_responder mgmt_phy_checker chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .cmdStart(regWrData[11]), .cmdOp(regWrData[15:14]),
  .regRdData(regRdData), .cmdDone(cmdDone)
);

// File: tb/mgmt_phy_responder_tb.sv
`timescale 1ns/1ps
module mgmt_phy_responder_tb_top;
  localparam logic [4:0] OWN = 5'd7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linkUp = 1'b1;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cmdDone;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl [32];

  always #2.5 clk = ~clk;

  mgmt_phy_responder #(.PHY_ADDR(OWN)) dut_i (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cmdDone(cmdDone)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic hostWr(input logic [1:0] a, input logic [31:0] d, output logic dn);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    dn = cmdDone;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic hostRd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [31:0] cmdWord(input logic [4:0] pa, input logic [4:0] ra,
                                          input logic [1:0] op, input logic st);
    return (32'(pa) << 24) | (32'(ra) << 16) | (32'(op) << 14) | (32'(st) << 11);
  endfunction

  task automatic phyRead(input logic [4:0] pa, input logic [4:0] ra,
                         output logic [15:0] v, output logic dn);
    logic [31:0] r;
    hostWr(2'd1, cmdWord(pa, ra, 2'd2, 1'b1), dn);
    hostRd(2'd3, r);
    v = r[15:0];
  endtask

  task automatic phyWrite(input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] d, output logic dn);
    logic x;
    hostWr(2'd2, 32'(d), x);
    hostWr(2'd1, cmdWord(pa, ra, 2'd1, 1'b1), dn);
  endtask

  function automatic logic [15:0] expPhy(input int r);
    logic [15:0] a;
    a = mdl[4];
    case (r)
      1:  return linkUp ? 16'h782E : 16'h0000;
      5:  return 16'h4000 | (a & 16'h01E0) | 16'h0001;
      17: return 16'h8000;
      18: return linkUp ? {4'b0, a[8] | a[6], a[7] | a[8], 10'b0} : 16'h0000;
      default: return mdl[r];
    endcase
  endfunction

  function automatic string tagFor(input int r);
    if (r == 1) return "R7";
    if (r == 5) return "R8";
    if (r == 17 || r == 18) return "R9";
    return "R6";
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finishRun();
  end

  initial begin
    logic [31:0] rv;
    logic [15:0] pv;
    logic dn;

    for (int i = 0; i < 32; i++) mdl[i] = 16'h0000;
    mdl[0] = 16'h3100; mdl[2] = 16'h0300; mdl[3] = 16'hE400; mdl[4] = 16'h01E1;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1 check("R1 done idle", 32'(cmdDone), 0);
    hostRd(2'd0, rv); check("R5 cfg reset", rv, 32'h0);
    hostRd(2'd1, rv); check("R4 cmd reset", rv, 32'h80);
    hostRd(2'd3, rv); check("R11 rdata reset", rv, 32'h0);

    // reset contents and derived registers, link up
    for (int r = 0; r < 32; r++) begin
      phyRead(OWN, 5'(r), pv, dn);
      check({tagFor(r), " reset read"}, 32'(pv), 32'(expPhy(r)));
      check("R1 read done", 32'(dn), 1);
    end

    // link down
    linkUp = 1'b0;
    phyRead(OWN, 5'd1, pv, dn);  check("R7 link down", 32'(pv), 32'(expPhy(1)));
    phyRead(OWN, 5'd18, pv, dn); check("R9 diag link down", 32'(pv), 32'(expPhy(18)));
    phyRead(OWN, 5'd5, pv, dn);  check("R8 partner link down", 32'(pv), 32'(expPhy(5)));
    linkUp = 1'b1;

    // advertisement sweep, both link states
    for (int k = 0; k < 16; k++) begin
      phyWrite(OWN, 5'd4, 16'h0001 | 16'(k << 5), dn);
      check("R1 write done", 32'(dn), 1);
      mdl[4] = 16'h0001 | 16'(k << 5);
      for (int l = 0; l < 2; l++) begin
        linkUp = l[0];
        phyRead(OWN, 5'd5, pv, dn);  check("R8 adv sweep", 32'(pv), 32'(expPhy(5)));
        phyRead(OWN, 5'd18, pv, dn); check("R9 adv sweep", 32'(pv), 32'(expPhy(18)));
        phyRead(OWN, 5'd1, pv, dn);  check("R7 adv sweep", 32'(pv), 32'(expPhy(1)));
      end
    end
    linkUp = 1'b1;

    // write a distinct pattern everywhere, read back
    for (int r = 0; r < 32; r++) begin
      logic [15:0] p;
      p = 16'((r + 1) * 16'h1357) ^ 16'hC0DE;
      phyWrite(OWN, 5'(r), p, dn);
      mdl[r] = (r == 0) ? (p & 16'h7FFF) : p;
    end
    for (int r = 0; r < 32; r++) begin
      phyRead(OWN, 5'(r), pv, dn);
      check((r == 0) ? "R10 pattern" : (tagFor(r) == "R6" ? "R2 pattern" : tagFor(r)),
            32'(pv), 32'(expPhy(r)));
    end

    // reset bit self-clears
    phyWrite(OWN, 5'd0, 16'hFFFF, dn); mdl[0] = 16'h7FFF;
    phyRead(OWN, 5'd0, pv, dn); check("R10 reg0 full", 32'(pv), 32'h7FFF);
    phyWrite(OWN, 5'd9, 16'h0F0F, dn); mdl[9] = 16'h0F0F;
    phyRead(OWN, 5'd0, pv, dn); check("R10 after other write", 32'(pv[15]), 0);

    // foreign addresses
    for (int a = 0; a < 32; a++) begin
      if (a != int'(OWN)) begin
        phyRead(5'(a), 5'd2, pv, dn);
        check("R3 foreign read", 32'(pv), 32'hFFFF);
        check("R1 foreign done", 32'(dn), 1);
        phyWrite(5'(a), 5'd2, 16'hDEAD, dn);
      end
    end
    phyRead(OWN, 5'd2, pv, dn); check("R3 own reg kept", 32'(pv), 32'(mdl[2]));

    // ignored commands
    phyRead(OWN, 5'd17, pv, dn);
    hostWr(2'd2, 32'h0000BEEF, dn);
    hostWr(2'd1, cmdWord(OWN, 5'd2, 2'd0, 1'b1), dn); check("R11 op0 done", 32'(dn), 0);
    hostRd(2'd3, rv); check("R11 op0 rdata", rv, 32'h8000);
    hostWr(2'd1, cmdWord(OWN, 5'd2, 2'd3, 1'b1), dn); check("R11 op3 done", 32'(dn), 0);
    hostRd(2'd3, rv); check("R11 op3 rdata", rv, 32'h8000);
    hostWr(2'd1, cmdWord(OWN, 5'd2, 2'd2, 1'b0), dn); check("R11 nostart done", 32'(dn), 0);
    hostRd(2'd3, rv); check("R11 nostart rdata", rv, 32'h8000);
    hostWr(2'd1, cmdWord(OWN, 5'd2, 2'd1, 1'b0), dn); check("R11 nostart wr done", 32'(dn), 0);
    phyRead(OWN, 5'd2, pv, dn); check("R11 reg unchanged", 32'(pv), 32'(mdl[2]));

    // command, config and write-data readback
    hostWr(2'd1, 32'h1F1F0000, dn); hostRd(2'd1, rv); check("R4 cmd readback", rv, 32'h1F1F0080);
    hostWr(2'd1, 32'hFFFFFFFF, dn); check("R1 op3 all ones", 32'(dn), 0);
    hostRd(2'd1, rv); check("R4 cmd all ones", rv, 32'hFFFFFFFF);
    hostWr(2'd0, 32'hFFFFFFFF, dn); hostRd(2'd0, rv); check("R5 cfg mask", rv, 32'h7F);
    hostWr(2'd0, 32'h12345645, dn); hostRd(2'd0, rv); check("R5 cfg value", rv, 32'h45);
    hostWr(2'd2, 32'hA5A55A5A, dn); hostRd(2'd2, rv); check("R2 wdata readback", rv, 32'hA5A55A5A);

    finishRun();
  end
endmodule